// File: doc/BRIEF.md
# Random Number Generator Control Register Block

This block is a small register file for a random number source. A host reaches it over a simple bus: one address, a write enable with write data, a read enable, and read data. The read data is combinational from the address. The block runs two long operations, seeding and self-test. A host starts each one by writing a bit to a command register. Each operation moves from idle to running, and then to done after a fixed number of clock cycles.

Progress shows up in three places: the command readback, the status register with its busy/idle pair and per-operation done flags, and a level interrupt. A control register holds the interrupt masks and an auto-seed flag. Each read of the data register returns the next word of an internal 32-bit LFSR, which stands in for a real entropy source.

A soft-reset command bit returns the operations and the control bits to their reset values. It does not change the interrupt line.

Top module: `rng_ctrl_regs`

## Requirements
- R1: Mapped byte offsets are 0x00 version, 0x04 command, 0x08 control, 0x0C status and 0x14 data. Reads of any other offset return 0, and writes to any other offset change nothing.
- R2: The version register reads 0x1000_0240: type 1 in bits 31:28, major 2 in bits 15:8, minor 0x40 in bits 7:0.
- R3: A command write acts on all of its set bits together: bit 6 soft reset, bit 5 clear error, bit 4 clear interrupt, bit 1 start seed, bit 0 start self-test. A start bit moves its operation to running at that clock edge.
- R4: The command register reads bit 1 = seeding running and bit 0 = self-test running. All other bits read 0.
- R5: Control bit 6 is the error mask, bit 5 is the done mask and bit 4 is auto-seed. Every control write replaces all three, and reads return them with all other bits 0.
- R6: Status reads 5 in bits 15:12, 5 in bits 11:8 and 1 in bit 6. Bit 5 is set while seeding is done and bit 4 while self-test is done. All other bits not named here read 0.
- R7: Status bit 1 (busy) is set while either operation runs, and otherwise status bit 0 (idle) is set. Exactly one of the two is set.
- R8: An operation becomes done DONE_DELAY clock edges after its start edge (default 16). A start while it is running reloads the full delay.
- R9: On completion the interrupt rises at the same edge, unless the done mask is set at that time. The error mask has no effect on it.
- R10: The interrupt is a held level. A command write with bit 5 or bit 4 set drops it at that edge, unless a completion raises it at the same edge, in which case it stays high.
- R11: Soft reset returns both operations to idle, which clears the done flags, and clears both masks and auto-seed. It leaves the interrupt unchanged. A start bit in the same write still starts its operation.
- R12: A data read returns the LFSR state and advances the state at that edge. The state starts at 0xACE1_2468 and advances as next = (s >> 1) ^ (s[0] ? 0x8020_0003 : 0). No other access advances it.
- R13: Hardware reset (rstN low) gives idle operations, zero control bits, interrupt low and the LFSR at its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the access |
| wrEn | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdEn | input | 1 | Read strobe (advances the LFSR on a data read) |
| rdata | output | 32 | Read data for addr |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench counts edges exactly around completion: the operation must still be running after DONE_DELAY-1 edges and be done after DONE_DELAY edges. A counter that is off by one fails on one side of that window. It restarts a running self-test and expects the full delay again, which catches a design that ignores the restart or keeps the old count. It places an interrupt clear on the completion edge and expects the line to stay high, which exposes a clear that wins over a set. It also fires soft reset while the interrupt is pending, where a design that drops the line or keeps the masks is caught. Data reads are compared against an LFSR model, with status reads and strobed reads of other addresses placed between them, so a generator that steps on the wrong access shows as a shifted sequence.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} opState_t;

  typedef enum logic [2:0] {SEL_VER, SEL_CMD, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_NONE} regSel_t;

  // Operation index: 0 = self-test, 1 = seed (matches command bit order)
  localparam int NUM_OPS = 2;
  localparam int OP_TEST = 0;
  localparam int OP_SEED = 1;

  typedef struct packed {
    logic                softRst;
    logic                irqClr;
    logic [NUM_OPS-1:0]  start;
    logic                ctrlWr;
    logic [2:0]          ctrlVal; // {maskErr, maskDone, autoSeed}
    logic                dataStep;
  } ctlStrobes_t;

  localparam logic [31:0] VERSION_WORD = 32'h1000_0240;
endpackage

// File: rtl/rngc_op_seq.sv
module rngc_op_seq
  import rngc_pkg::*;
#(
  parameter int DONE_DELAY = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     softRst,
  output opState_t state,
  output logic     doneEvt
);
  localparam int CNT_W = $clog2(DONE_DELAY + 1);

  logic [CNT_W-1:0] cnt;

  assign doneEvt = !start && !softRst && (state == ST_RUN) && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (start) begin
      state <= ST_RUN;
      cnt   <= CNT_W'(DONE_DELAY);
    end else if (softRst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (state == ST_RUN) begin
      if (cnt == CNT_W'(1)) begin
        state <= ST_DONE;
        cnt   <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rngc_ctrl.sv
module rngc_ctrl
  import rngc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wdata,
  input  logic              rdEn,
  output regSel_t           regSel,
  output ctlStrobes_t       strobes
);
  always_comb begin
    case (addr)
      ADDR_W'(8'h00): regSel = SEL_VER;
      ADDR_W'(8'h04): regSel = SEL_CMD;
      ADDR_W'(8'h08): regSel = SEL_CTRL;
      ADDR_W'(8'h0C): regSel = SEL_STAT;
      ADDR_W'(8'h14): regSel = SEL_DATA;
      default:        regSel = SEL_NONE;
    endcase
  end

  logic cmdWr;
  assign cmdWr = wrEn && (regSel == SEL_CMD);

  always_comb begin
    strobes          = '0;
    strobes.softRst  = cmdWr && wdata[6];
    strobes.irqClr   = cmdWr && (wdata[5] || wdata[4]);
    strobes.start[OP_SEED] = cmdWr && wdata[1];
    strobes.start[OP_TEST] = cmdWr && wdata[0];
    strobes.ctrlWr   = wrEn && (regSel == SEL_CTRL);
    strobes.ctrlVal  = wdata[6:4];
    strobes.dataStep = rdEn && (regSel == SEL_DATA);
  end
endmodule

// File: rtl/rngc_datapath.sv
module rngc_datapath
  import rngc_pkg::*;
#(
  parameter int          DONE_DELAY = 16,
  parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468,
  parameter logic [31:0] LFSR_TAPS  = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  regSel_t     regSel,
  output logic [31:0] rdata,
  output logic        irq
);
  opState_t           opState [NUM_OPS];
  logic [NUM_OPS-1:0] opDone;
  logic [NUM_OPS-1:0] opRun;
  logic [NUM_OPS-1:0] opFin;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    rngc_op_seq #(.DONE_DELAY(DONE_DELAY)) u_seq (
      .clk     (clk),
      .rstN    (rstN),
      .start   (strobes.start[i]),
      .softRst (strobes.softRst),
      .state   (opState[i]),
      .doneEvt (opDone[i])
    );
    assign opRun[i] = (opState[i] == ST_RUN);
    assign opFin[i] = (opState[i] == ST_DONE);
  end

  logic maskErr, maskDone, autoSeed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {maskErr, maskDone, autoSeed} <= 3'b000;
    end else if (strobes.softRst) begin
      {maskErr, maskDone, autoSeed} <= 3'b000;
    end else if (strobes.ctrlWr) begin
      {maskErr, maskDone, autoSeed} <= strobes.ctrlVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if ((|opDone) && !maskDone) begin
      irq <= 1'b1;
    end else if (strobes.irqClr) begin
      irq <= 1'b0;
    end
  end

  logic [31:0] lfsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else if (strobes.dataStep) begin
      lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : 32'h0);
    end
  end

  logic busy;
  assign busy = |opRun;

  always_comb begin
    rdata = '0;
    case (regSel)
      SEL_VER:  rdata = VERSION_WORD;
      SEL_CMD:  rdata[1:0] = {opRun[OP_SEED], opRun[OP_TEST]};
      SEL_CTRL: rdata[6:4] = {maskErr, maskDone, autoSeed};
      SEL_STAT: begin
        rdata[15:12] = 4'd5;
        rdata[11:8]  = 4'd5;
        rdata[6]     = 1'b1;
        rdata[5]     = opFin[OP_SEED];
        rdata[4]     = opFin[OP_TEST];
        rdata[1]     = busy;
        rdata[0]     = !busy;
      end
      SEL_DATA: rdata = lfsr;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rngc_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DONE_DELAY = 16,
  parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wdata,
  input  logic              rdEn,
  output logic [31:0]       rdata,
  output logic              irq
);
  regSel_t     regSel;
  ctlStrobes_t strobes;

  rngc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .wdata   (wdata),
    .rdEn    (rdEn),
    .regSel  (regSel),
    .strobes (strobes)
  );

  rngc_datapath #(
    .DONE_DELAY (DONE_DELAY),
    .LFSR_SEED  (LFSR_SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regSel  (regSel),
    .rdata   (rdata),
    .irq     (irq)
  );
endmodule

// File: rtl/rngc_regs_chk.sv
module rngc_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq
);
  logic mapped;
  assign mapped = (addr == ADDR_W'(8'h00)) || (addr == ADDR_W'(8'h04)) ||
                  (addr == ADDR_W'(8'h08)) || (addr == ADDR_W'(8'h0C)) ||
                  (addr == ADDR_W'(8'h14));

  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> rdata == 32'h0);

  assert_version_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(8'h00) |-> rdata == 32'h1000_0240);

  assert_cmd_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(8'h04) |-> rdata[31:2] == 30'h0);

  assert_ctrl_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(8'h08) |-> (rdata[31:7] == 25'h0 && rdata[3:0] == 4'h0));

  assert_status_const_R6: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(8'h0C) |-> (rdata[15:6] == 10'b0101_0101_01 && rdata[31:16] == 16'h0));

  assert_busy_idle_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(8'h0C) |-> $countones(rdata[1:0]) == 1);

  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && addr == ADDR_W'(8'h04) && (wdata[5] || wdata[4]))) |=> irq);
endmodule

bind rng_ctrl_regs rngc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .addr  (addr),
  .wrEn  (wrEn),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq)
);

// File: tb/rng_ctrl_regs_tb.sv
module rng_ctrl_regs_tb;
  localparam int ADDR_W = 8;
  localparam int DELAY  = 16;
  localparam logic [31:0] SEED = 32'hACE1_2468;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [31:0]       wdata = '0;
  logic              rdEn = 1'b0;
  logic [31:0]       rdata;
  logic              irq;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;
  logic [31:0] model = SEED;

  always #10 clk = ~clk; // 50 MHz

  rng_ctrl_regs #(.ADDR_W(ADDR_W), .DONE_DELAY(DELAY), .LFSR_SEED(SEED)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wdata(wdata),
    .rdEn(rdEn), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  // Write: driven at a negedge, taken at the next posedge, returns at the following negedge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  // Register read without strobe: no edge consumed
  task automatic busPeek(input logic [7:0] a, output logic [31:0] d);
    addr = ADDR_W'(a); rdEn = 1'b0;
    #2 d = rdata;
  endtask

  // Strobed read: consumes one edge
  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    addr = ADDR_W'(a); rdEn = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tResetState();
    logic [31:0] v;
    check("R13 irq after reset", {31'b0, irq}, 32'h0);
    busPeek(8'h04, v); check("R13 cmd after reset", v, 32'h0);
    busPeek(8'h08, v); check("R13 ctrl after reset", v, 32'h0);
    busPeek(8'h0C, v); check("R6 status idle", v, 32'h0000_5541);
    busPeek(8'h00, v); check("R2 version", v, 32'h1000_0240);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h18, 32'hFFFF_FFFF);
    busPeek(8'h10, v); check("R1 unmapped 0x10 reads 0", v, 32'h0);
    busPeek(8'h18, v); check("R1 unmapped 0x18 reads 0", v, 32'h0);
    busPeek(8'h08, v); check("R1 unmapped write leaves ctrl", v, 32'h0);
    busPeek(8'h04, v); check("R1 unmapped write starts nothing", v, 32'h0);
    check("R1 unmapped write irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic tControl();
    logic [31:0] v;
    busWrite(8'h08, 32'h0000_0070); busPeek(8'h08, v); check("R5 ctrl all set", v, 32'h70);
    busWrite(8'h08, 32'hFFFF_FFFF); busPeek(8'h08, v); check("R5 ctrl reserved dropped", v, 32'h70);
    busWrite(8'h08, 32'h0000_0020); busPeek(8'h08, v); check("R5 ctrl replace", v, 32'h20);
    busWrite(8'h08, 32'h0);         busPeek(8'h08, v); check("R5 ctrl clear", v, 32'h0);
  endtask

  task automatic tSeedOp();
    logic [31:0] v;
    busWrite(8'h04, 32'h2);
    busPeek(8'h04, v); check("R3 seed start running", v, 32'h2);
    busPeek(8'h0C, v); check("R7 busy while running", v, 32'h5542);
    waitEdges(DELAY - 1);
    busPeek(8'h04, v); check("R8 seed still running at DELAY-1", v, 32'h2);
    check("R9 irq low before done", {31'b0, irq}, 32'h0);
    waitEdges(1);
    busPeek(8'h04, v); check("R4 seed no longer running", v, 32'h0);
    busPeek(8'h0C, v); check("R6 seed done flag", v, 32'h5561);
    check("R9 irq raised at completion", {31'b0, irq}, 32'h1);
    busWrite(8'h04, 32'h10);
    check("R10 clear-interrupt drops irq", {31'b0, irq}, 32'h0);
    busPeek(8'h0C, v); check("R6 done flag survives irq clear", v, 32'h5561);
  endtask

  task automatic tBothMasked();
    logic [31:0] v;
    busWrite(8'h08, 32'h20);
    busWrite(8'h04, 32'h3);
    busPeek(8'h04, v); check("R3 both started in one write", v, 32'h3);
    waitEdges(DELAY);
    busPeek(8'h0C, v); check("R6 both done", v, 32'h5571);
    check("R9 done mask suppresses irq", {31'b0, irq}, 32'h0);
    busWrite(8'h08, 32'h40);
    busWrite(8'h04, 32'h1);
    waitEdges(DELAY);
    check("R9 error mask does not stop done irq", {31'b0, irq}, 32'h1);
    busWrite(8'h04, 32'h20);
    check("R10 clear-error drops irq", {31'b0, irq}, 32'h0);
    busWrite(8'h08, 32'h0);
  endtask

  task automatic tRestart();
    logic [31:0] v;
    busWrite(8'h04, 32'h1);
    waitEdges(7);
    busWrite(8'h04, 32'h1);
    waitEdges(DELAY - 1);
    busPeek(8'h04, v); check("R8 restart reloads delay", v, 32'h1);
    check("R8 no irq before reloaded delay", {31'b0, irq}, 32'h0);
    waitEdges(1);
    busPeek(8'h04, v); check("R8 restarted test done", v, 32'h0);
    check("R9 irq after restarted test", {31'b0, irq}, 32'h1);
    busWrite(8'h04, 32'h10);
  endtask

  task automatic tSetWins();
    busWrite(8'h04, 32'h1);
    waitEdges(DELAY - 1);
    busWrite(8'h04, 32'h10); // clear lands on the completion edge
    check("R10 completion beats clear", {31'b0, irq}, 32'h1);
    busWrite(8'h04, 32'h10);
    check("R10 later clear works", {31'b0, irq}, 32'h0);
  endtask

  task automatic tSoftReset();
    logic [31:0] v;
    busWrite(8'h04, 32'h1);
    waitEdges(DELAY);
    check("R9 irq pending before soft reset", {31'b0, irq}, 32'h1);
    busWrite(8'h08, 32'h70);
    busWrite(8'h04, 32'h2);
    busWrite(8'h04, 32'h40);
    busPeek(8'h04, v); check("R11 soft reset idles ops", v, 32'h0);
    busPeek(8'h0C, v); check("R11 soft reset clears done flags", v, 32'h5541);
    busPeek(8'h08, v); check("R11 soft reset clears ctrl", v, 32'h0);
    check("R11 soft reset keeps irq", {31'b0, irq}, 32'h1);
    busWrite(8'h04, 32'h52); // soft reset + clear int + start seed
    busPeek(8'h04, v); check("R11 start in soft reset write", v, 32'h2);
    check("R3 clear acted in same write", {31'b0, irq}, 32'h0);
    waitEdges(DELAY);
    busPeek(8'h0C, v); check("R11 seed completes after soft reset", v, 32'h5561);
    busWrite(8'h04, 32'h10);
  endtask

  task automatic tData();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      busRead(8'h14, v); check("R12 lfsr word", v, model); model = lfsrNext(model);
    end
    busRead(8'h0C, v);   // strobed read of another register
    busPeek(8'h14, v);   // unstrobed data view
    busRead(8'h08, v);
    busRead(8'h14, v); check("R12 other reads do not step", v, model); model = lfsrNext(model);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h14, v); check("R12 data write ignored", v, model); model = lfsrNext(model);
  endtask

  task automatic tHardReset();
    logic [31:0] v;
    busWrite(8'h08, 32'h50);
    busWrite(8'h04, 32'h3);
    waitEdges(DELAY);
    check("R9 irq before hard reset", {31'b0, irq}, 32'h1);
    rstN = 1'b0;
    #3;
    check("R13 hard reset irq", {31'b0, irq}, 32'h0);
    busPeek(8'h0C, v); check("R13 hard reset status", v, 32'h5541);
    busPeek(8'h08, v); check("R13 hard reset ctrl", v, 32'h0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    busRead(8'h14, v); check("R13 lfsr reseeded", v, SEED);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tUnmapped();
    tControl();
    tSeedOp();
    tBothMasked();
    tRestart();
    tSetWins();
    tSoftReset();
    tData();
    tHardReset();
    summary();
  end
endmodule